// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block sits beside an 8-bit CPU core and arbitrates five interrupt sources. Two CPU-visible registers set which interrupts can fire: an enable mask and a request flag register. Together with a master enable bit, these registers decide when the core is asked to take an interrupt. A source sets its request flag bit. A line is pending when its bit is set in both registers. While the master enable is on, the lowest-numbered pending line is presented to the core together with its vector.

The core acknowledges the request when it starts the service sequence. On that edge the controller drops the master enable and clears the flag bit that was serviced. The instruction decoder drives enable and disable commands. A disable acts immediately. An enable is held back until the next instruction boundary that follows it. A small detector also raises the bit-0 request when the scanline counter enters the first blanking line.

Top module: `irq_ctrl`

## Requirements
- R1: `irq_req_o` is high exactly when `ime_o` is high and at least one bit is set in both the enable register and the flag register.
- R2: When several lines are pending, bit 0 has the highest priority and bit 4 the lowest. `irq_vec_o` is 0x40 + 8 × (index of the winning bit), so the vectors run 0x40, 0x48, 0x50, 0x58 and 0x60.
- R3: An acknowledge cycle is one where `irq_ack_i` is high while `irq_req_o` is high. On that clock edge the master enable is cleared, so `ime_o` and `irq_req_o` are low in the next cycle.
- R4: An acknowledge cycle clears only the flag bit of the line that was presented. All other flag bits are kept.
- R5: After a cycle with `ei_i` high while the master enable is off, `ime_o` stays low until the first `step_i` pulse in a later cycle. It goes high on the edge of that pulse.
- R6: `di_i` clears the master enable on its clock edge and also cancels an enable that is still waiting for its step.
- R7: A write with `reg_sel_i`=1 loads flag bits 4:0 from the write data, which can set or clear any of them. Reads with `reg_sel_i`=1 return 1 in bits 7:5.
- R8: A write with `reg_sel_i`=0 loads the full 8-bit enable register, and a read returns the stored value.
- R9: A high bit on `src_req_i` sets the matching flag bit on that edge. This holds even if a bus write or an acknowledge clears that bit in the same cycle.
- R10: Flag bit 0 is set once when `scanline_i` changes to 144 from another value. It is not set again while the counter stays at 144.
- R11: `irq_ack_i` has no effect on the flag register or the master enable while `irq_req_o` is low.
- R12: After reset, the enable register reads 0x00, the flag register reads 0xE0, and `ime_o` and `irq_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 flag |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| src_req_i | input | 5 | Request pulses from the sources |
| scanline_i | input | 8 | Current scanline counter |
| ei_i | input | 1 | Enable-interrupt command |
| di_i | input | 1 | Disable-interrupt command |
| step_i | input | 1 | Instruction boundary pulse |
| irq_ack_i | input | 1 | Core accepts the presented interrupt |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector of the presented interrupt |
| ime_o | output | 1 | Master enable state |

## Verification
The assertions check the relations that hold on every cycle:
- a request never appears without the master enable;
- the vector is always one of the five legal values;
- an acknowledge or a disable clears the master enable by the next cycle;
- an enable never becomes active in the cycle right after the command, and it only becomes active after a step;
- the flag read always shows ones in bits 7:5.

Some properties need chosen stimulus and known register contents, so only the bench's scenarios can show them:
- the exact order of priorities and the vector for each line;
- that an acknowledge clears only the serviced bit;
- that a disable cancels a waiting enable;
- that a source request wins over a clear in the same cycle;
- that the scanline detector fires only once.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_SRC_DEF = 5;
  localparam int unsigned DATA_W_DEF  = 8;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAG   = 1'b1
  } reg_sel_e;

  function automatic logic [7:0] calc_vec(input logic [7:0] base,
                                          input logic [7:0] stride,
                                          input logic [7:0] idx);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/irq_vblank_det.sv
module irq_vblank_det #(
  parameter int unsigned LINE_W      = 8,
  parameter int unsigned VBLANK_LINE = 144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] scanline_i,
  output logic              vblank_o
);
  localparam logic [LINE_W-1:0] LINE_HIT = LINE_W'(VBLANK_LINE);

  logic at_line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) at_line_q <= 1'b0;
    else         at_line_q <= (scanline_i == LINE_HIT);
  end

  // pulse only on entry to the line
  assign vblank_o = (scanline_i == LINE_HIT) && !at_line_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  import irq_ctrl_pkg::*;

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  enable_q;
  logic [NUM_SRC-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (reg_wr_i && reg_sel_i == SEL_FLAG) flag_d = reg_wdata_i[NUM_SRC-1:0];
    flag_d = (flag_d & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      flag_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (reg_wr_i && reg_sel_i == SEL_ENABLE) enable_q <= reg_wdata_i;
    end
  end

  assign reg_rdata_o = (reg_sel_i == SEL_FLAG) ? {{PAD_W{1'b1}}, flag_q} : enable_q;
  assign pend_o      = enable_q[NUM_SRC-1:0] & flag_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant_o[i] = pend_i[i];
    end else begin : g_rest
      assign grant_o[i] = pend_i[i] && !(|pend_i[i-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/irq_ime.sv
module irq_ime (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic step_i,
  input  logic take_i,
  output logic ime_o
);
  logic ime_q, wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ime_q  <= 1'b0;
      wait_q <= 1'b0;
    end else if (di_i || take_i) begin
      ime_q  <= 1'b0;
      wait_q <= 1'b0;
    end else if (ei_i) begin
      wait_q <= !ime_q;
    end else if (wait_q && step_i) begin
      ime_q  <= 1'b1;
      wait_q <= 1'b0;
    end
  end

  assign ime_o = ime_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned NUM_SRC     = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LINE_W      = 8,
  parameter int unsigned VBLANK_LINE = 144,
  parameter logic [7:0]  VEC_BASE    = 8'h40,
  parameter logic [7:0]  VEC_STRIDE  = 8'h08
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [LINE_W-1:0]  scanline_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               step_i,
  input  logic               irq_ack_i,
  output logic               irq_req_o,
  output logic [7:0]         irq_vec_o,
  output logic               ime_o
);
  import irq_ctrl_pkg::*;

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               vblank;
  logic [NUM_SRC-1:0] set_mask, clr_mask, pend, grant;
  logic [IDX_W-1:0]   idx;
  logic               any_pend, take;

  irq_vblank_det #(.LINE_W(LINE_W), .VBLANK_LINE(VBLANK_LINE)) u_vblank (
    .clk_i, .rst_ni, .scanline_i, .vblank_o(vblank)
  );

  always_comb begin
    set_mask    = src_req_i;
    set_mask[0] = src_req_i[0] | vblank;
  end

  assign take     = irq_ack_i && irq_req_o;
  assign clr_mask = take ? grant : '0;

  irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .set_i(set_mask), .clr_i(clr_mask), .pend_o(pend)
  );

  irq_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i(pend), .grant_o(grant), .idx_o(idx), .any_o(any_pend)
  );

  irq_ime u_ime (
    .clk_i, .rst_ni, .ei_i, .di_i, .step_i, .take_i(take), .ime_o
  );

  assign irq_req_o = ime_o && any_pend;
  assign irq_vec_o = calc_vec(VEC_BASE, VEC_STRIDE, 8'(idx));
endmodule

// File: rtl/irq_ctrl_sva.sv
module irq_ctrl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_sel_i,
  input logic [7:0] reg_rdata_o,
  input logic       ei_i,
  input logic       di_i,
  input logic       step_i,
  input logic       irq_ack_i,
  input logic       irq_req_o,
  input logic [7:0] irq_vec_o,
  input logic       ime_o
);
  AST_REQ_NEEDS_IME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ime_o); // R1
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o[2:0] == 3'b000 && irq_vec_o >= 8'h40 && irq_vec_o <= 8'h60)); // R2
  AST_ACK_DROPS_IME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> (!ime_o && !irq_req_o)); // R3
  AST_EI_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !ime_o) |=> !ime_o); // R5
  AST_IME_RISE_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ime_o) |-> $past(step_i)); // R5
  AST_DI_DROPS_IME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !ime_o); // R6
  AST_FLAG_PAD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> reg_rdata_o[7:5] == 3'b111); // R7
endmodule

bind irq_ctrl irq_ctrl_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_sel_i(reg_sel_i), .reg_rdata_o(reg_rdata_o),
  .ei_i(ei_i), .di_i(di_i), .step_i(step_i), .irq_ack_i(irq_ack_i),
  .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .ime_o(ime_o)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [4:0] src_req_i = '0;
  logic [7:0] scanline_i = '0;
  logic       ei_i = 1'b0, di_i = 1'b0, step_i = 1'b0, irq_ack_i = 1'b0;
  logic       irq_req_o, ime_o;
  logic [7:0] irq_vec_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  irq_ctrl dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    tick();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  task automatic enable_ime();
    ei_i = 1'b1; tick(); ei_i = 1'b0;
    step_i = 1'b1; tick(); step_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); check("R12 enable", d, 8'h00);
    rd(1'b1, d); check("R12 flag", d, 8'hE0);
    check("R12 ime", 8'(ime_o), 8'h00);
    check("R12 req", 8'(irq_req_o), 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(1'b0, 8'hA5); rd(1'b0, d); check("R8 enable rw", d, 8'hA5);
    wr(1'b1, 8'h1F); rd(1'b1, d); check("R7 flag set", d, 8'hFF);
    wr(1'b1, 8'h00); rd(1'b1, d); check("R7 flag clear", d, 8'hE0);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_ei_delay();
    ei_i = 1'b1; step_i = 1'b1; tick(); ei_i = 1'b0; step_i = 1'b0;
    check("R5 same-cycle step ignored", 8'(ime_o), 8'h00);
    tick();
    check("R5 no step yet", 8'(ime_o), 8'h00);
    step_i = 1'b1; tick(); step_i = 1'b0;
    check("R5 enabled after step", 8'(ime_o), 8'h01);
  endtask

  task automatic t_di();
    di_i = 1'b1; tick(); di_i = 1'b0;
    check("R6 di clears", 8'(ime_o), 8'h00);
    ei_i = 1'b1; tick(); ei_i = 1'b0;
    di_i = 1'b1; tick(); di_i = 1'b0;
    step_i = 1'b1; tick(); step_i = 1'b0;
    check("R6 cancel waiting enable", 8'(ime_o), 8'h00);
  endtask

  task automatic t_pending();
    enable_ime();
    wr(1'b0, 8'h04); wr(1'b1, 8'h02); #1;
    check("R1 no overlap", 8'(irq_req_o), 8'h00);
    wr(1'b1, 8'h06); #1;
    check("R1 overlap req", 8'(irq_req_o), 8'h01);
    check("R2 vec bit2", irq_vec_o, 8'h50);
    di_i = 1'b1; tick(); di_i = 1'b0; #1;
    check("R1 ime off blocks", 8'(irq_req_o), 8'h00);
  endtask

  task automatic t_priority();
    wr(1'b0, 8'h1F);
    enable_ime();
    wr(1'b1, 8'h1C); #1; check("R2 vec 1C", irq_vec_o, 8'h50);
    wr(1'b1, 8'h18); #1; check("R2 vec 18", irq_vec_o, 8'h58);
    wr(1'b1, 8'h10); #1; check("R2 vec 10", irq_vec_o, 8'h60);
    wr(1'b1, 8'h1F); #1; check("R2 vec 1F", irq_vec_o, 8'h40);
    wr(1'b1, 8'h1E); #1; check("R2 vec 1E", irq_vec_o, 8'h48);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr(1'b1, 8'h0A); #1;
    check("R2 vec 0A", irq_vec_o, 8'h48);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    check("R3 ime cleared", 8'(ime_o), 8'h00);
    check("R3 req cleared", 8'(irq_req_o), 8'h00);
    rd(1'b1, d); check("R4 only serviced bit", d, 8'hE8);
  endtask

  task automatic t_ack_ignored();
    logic [7:0] d;
    wr(1'b1, 8'h03);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    rd(1'b1, d); check("R11 flags kept", d, 8'hE3);
    check("R11 ime still off", 8'(ime_o), 8'h00);
  endtask

  task automatic t_src();
    logic [7:0] d;
    wr(1'b1, 8'h00);
    src_req_i = 5'b01000; tick(); src_req_i = '0;
    rd(1'b1, d); check("R9 source sets", d, 8'hE8);
    src_req_i = 5'b00100; reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'h00;
    tick(); src_req_i = '0; reg_wr_i = 1'b0;
    rd(1'b1, d); check("R9 source beats write", d, 8'hE4);
    wr(1'b1, 8'h04); enable_ime(); #1;
    check("R2 vec bit2 only", irq_vec_o, 8'h50);
    src_req_i = 5'b00100; irq_ack_i = 1'b1; tick(); src_req_i = '0; irq_ack_i = 1'b0;
    rd(1'b1, d); check("R9 source beats ack", d, 8'hE4);
  endtask

  task automatic t_vblank();
    logic [7:0] d;
    wr(1'b1, 8'h00);
    scanline_i = 8'd143; tick();
    rd(1'b1, d); check("R10 not yet", d, 8'hE0);
    scanline_i = 8'd144; tick();
    rd(1'b1, d); check("R10 entry sets bit0", d, 8'hE1);
    wr(1'b1, 8'h00); tick(); tick();
    rd(1'b1, d); check("R10 held line no retrigger", d, 8'hE0);
    scanline_i = 8'd0; tick();
    scanline_i = 8'd144; tick();
    rd(1'b1, d); check("R10 re-entry sets", d, 8'hE1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_regs();
        t_ei_delay();
        t_di();
        t_pending();
        t_priority();
        t_ack();
        t_ack_ignored();
        t_src();
        t_vblank();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule